// File: doc/BRIEF.md
# Time-Slotted Operand Collector

This block drives a single 256-bit register-file port for a four-lane multiply-add unit. Each access moves one register group, which is four 64-bit lanes. A free-running four-cycle frame assigns the port to fixed duties:

- slot 0 reads the first source group;
- slot 1 reads the second source group;
- slot 2 reads the third source group;
- slot 3 writes one result group.

The groups read in slots 0 to 2 are held in collector flops. Once the set is complete, it is handed to the arithmetic pipeline over a valid/ready handshake.

An instruction may not need a third operand. In that case its slot 2 is lent to the memory side: a store reads a group out through the port, and a load writes a group in. A memory request is held by the requester until the block acknowledges it. The acknowledge is a single-cycle pulse one cycle after the slot that served the request.

The arithmetic itself is a stand-in: a pipeline of parameterised depth computes a lane-wise a*b+c, modulo 2^64. A result may come out of that pipeline outside a write slot. It is then parked in a one-entry buffer and written at the next slot 3.

Top module: `slot_collector`

## Requirements
- R1: After reset every register group reads as zero, `mem_ack` and `mem_rdata` are zero, and `issue_ready` is high in the first cycle.
- R2: Slot numbers run 0,1,2,3 repeating from the first cycle after reset. `issue_ready` is high only in slot 0. A request held across other slots is taken at the next slot 0.
- R3: Lane l of a result group (bits 64l+63 down to 64l) equals a*b+c modulo 2^64 of the source lanes. When `issue_use3` is 0 the third term is zero.
- R4: With the default pipeline depth, the result of an instruction accepted in cycle T is written at the end of cycle T+7 (a slot 3). A store served in cycle T+6 returns the old group; one served in cycle T+10 returns the result.
- R5: The port never reads and writes in the same cycle. Loads write only in slot 2 and results only in slot 3, so a loaded group is seen by an instruction issued after the load is acknowledged.
- R6: A memory request is served only in a slot-2 cycle that no three-operand instruction claims. `mem_ack` is a single-cycle pulse in the following cycle, which is always a slot 3.
- R7: A store returns the group at `mem_req_addr` on `mem_rdata`, and a load writes `mem_req_wdata` to it. A request raised together with a three-operand issue at cycle T is acknowledged at T+7. With a two-operand issue it is acknowledged at T+3.
- R8: With a five-stage pipeline, a result emerges in slot 0 and is held. It is written at the end of cycle T+11, so a store served at T+10 still sees the old group and one served at T+14 sees the result.
- R9: The collected operand set is released to the pipeline in slot 3 of the issue frame, once per accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction request |
| issue_ready | output | 1 | Instruction accepted this cycle when high with `issue_valid` |
| issue_rs1 | input | AW | First source group |
| issue_rs2 | input | AW | Second source group |
| issue_rs3 | input | AW | Third source group |
| issue_rd | input | AW | Destination group |
| issue_use3 | input | 1 | Instruction uses a third operand |
| mem_req_valid | input | 1 | Memory request, held until acknowledged |
| mem_req_store | input | 1 | 1 = store (read group out), 0 = load (write group in) |
| mem_req_addr | input | AW | Group addressed by the memory request |
| mem_req_wdata | input | GW | Load data |
| mem_ack | output | 1 | One-cycle acknowledge of a served request |
| mem_rdata | output | GW | Store data, valid with `mem_ack` |

## Verification
All timing is counted from the cycle T in which an issue is accepted. Because the slot counter is free-running from reset, the bench keeps its own cycle count and derives the slot from it. With that count it predicts the exact cycle of each acknowledge: T+3 when slot 2 is free, T+7 when a three-operand instruction holds it. Result visibility is pinned by stores served in known slot-2 cycles: T+6 and T+10 bracket the write for the default depth, and T+10 and T+14 bracket it for the five-stage instance. All outputs are sampled at the falling edge, so every value is read in the cycle it is due.

// File: rtl/slot_col_pkg.sv
package slot_col_pkg;
  typedef enum logic [1:0] {
    SL_RS1 = 2'd0,
    SL_RS2 = 2'd1,
    SL_RS3 = 2'd2,
    SL_WR  = 2'd3
  } slot_e;

  function automatic slot_e slot_next(input slot_e s);
    return slot_e'(s + 2'd1);
  endfunction
endpackage

// File: rtl/slot_col_seq.sv
module slot_col_seq
  import slot_col_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output slot_e slot
);
  always_ff @(posedge clk) begin
    if (!rst_n) slot <= SL_RS1;
    else        slot <= slot_next(slot);
  end
endmodule

// File: rtl/slot_col_bank.sv
module slot_col_bank #(
  parameter  int GROUPS = 16,
  parameter  int GW     = 256,
  localparam int AW     = $clog2(GROUPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [GW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [GW-1:0] rdata
);
  logic [GW-1:0] grp [GROUPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < GROUPS; i++) grp[i] <= '0;
    end else if (we) begin
      grp[waddr] <= wdata;
    end
  end

  assign rdata = grp[raddr];
endmodule

// File: rtl/slot_col_fma.sv
module slot_col_fma #(
  parameter  int LANES  = 4,
  parameter  int XLEN   = 64,
  parameter  int STAGES = 4,
  parameter  int AW     = 4,
  localparam int GW     = LANES * XLEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [GW-1:0] in_a,
  input  logic [GW-1:0] in_b,
  input  logic [GW-1:0] in_c,
  input  logic [AW-1:0] in_rd,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [GW-1:0] out_data,
  output logic [AW-1:0] out_rd
);
  function automatic logic [GW-1:0] group_madd(input logic [GW-1:0] a,
                                               input logic [GW-1:0] b,
                                               input logic [GW-1:0] c);
    logic [GW-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*XLEN +: XLEN] = a[l*XLEN +: XLEN] * b[l*XLEN +: XLEN] + c[l*XLEN +: XLEN];
    return r;
  endfunction

  logic          vld [STAGES];
  logic [AW-1:0] rds [STAGES];
  logic [GW-1:0] dat [STAGES];
  logic          adv;

  assign adv      = !vld[STAGES-1] || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) vld[i] <= 1'b0;
    end else if (adv) begin
      vld[0] <= in_valid;
      for (int i = 1; i < STAGES; i++) vld[i] <= vld[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      rds[0] <= in_rd;
      dat[0] <= group_madd(in_a, in_b, in_c);
      for (int i = 1; i < STAGES; i++) begin
        rds[i] <= rds[i-1];
        dat[i] <= dat[i-1];
      end
    end
  end

  assign out_valid = vld[STAGES-1];
  assign out_data  = dat[STAGES-1];
  assign out_rd    = rds[STAGES-1];
endmodule

// File: rtl/slot_collector.sv
module slot_collector
  import slot_col_pkg::*;
#(
  parameter  int GROUPS     = 16,
  parameter  int LANES      = 4,
  parameter  int XLEN       = 64,
  parameter  int FMA_STAGES = 4,
  localparam int GW         = LANES * XLEN,
  localparam int AW         = $clog2(GROUPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  output logic          issue_ready,
  input  logic [AW-1:0] issue_rs1,
  input  logic [AW-1:0] issue_rs2,
  input  logic [AW-1:0] issue_rs3,
  input  logic [AW-1:0] issue_rd,
  input  logic          issue_use3,
  input  logic          mem_req_valid,
  input  logic          mem_req_store,
  input  logic [AW-1:0] mem_req_addr,
  input  logic [GW-1:0] mem_req_wdata,
  output logic          mem_ack,
  output logic [GW-1:0] mem_rdata
);
  slot_e phase;

  // frame position
  slot_col_seq u_seq (.clk(clk), .rst_n(rst_n), .slot(phase));

  // instruction in flight through the read slots
  logic          act, use3_q;
  logic [AW-1:0] rs2_q, rs3_q, rd_q;

  // collector flops
  logic [GW-1:0] opa, opb, opc;
  logic [AW-1:0] op_rd;
  logic          op_valid, op_ready;

  // pipeline result side
  logic          res_valid, res_ready;
  logic [GW-1:0] res_data;
  logic [AW-1:0] res_rd;

  // parked result
  logic          buf_full;
  logic [GW-1:0] buf_data;
  logic [AW-1:0] buf_rd;

  // port control, named for the checker
  logic          issue_fire, rs3_claimed, mem_serve, load_we, res_we;
  logic          rf_we, rf_re;
  logic [AW-1:0] rf_waddr, rf_raddr;
  logic [GW-1:0] rf_wdata, rf_rdata;

  assign issue_ready = (phase == SL_RS1) && !buf_full && !op_valid;
  assign issue_fire  = issue_valid && issue_ready;
  assign rs3_claimed = act && use3_q;
  assign mem_serve   = (phase == SL_RS3) && mem_req_valid && !rs3_claimed;
  assign load_we     = mem_serve && !mem_req_store;
  assign res_ready   = !buf_full;
  assign res_we      = (phase == SL_WR) && (buf_full || res_valid);
  assign rf_we       = load_we || res_we;
  assign rf_re       = issue_fire
                     || ((phase == SL_RS2) && act)
                     || ((phase == SL_RS3) && (rs3_claimed || (mem_serve && mem_req_store)));

  always_comb begin
    rf_waddr = mem_req_addr;
    rf_wdata = mem_req_wdata;
    if (res_we) begin
      rf_waddr = buf_full ? buf_rd   : res_rd;
      rf_wdata = buf_full ? buf_data : res_data;
    end
  end

  always_comb begin
    unique case (phase)
      SL_RS1:  rf_raddr = issue_rs1;
      SL_RS2:  rf_raddr = rs2_q;
      SL_RS3:  rf_raddr = rs3_claimed ? rs3_q : mem_req_addr;
      default: rf_raddr = rd_q;
    endcase
  end

  slot_col_bank #(.GROUPS(GROUPS), .GW(GW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rf_raddr), .rdata(rf_rdata)
  );

  // control state of the collector
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= 1'b0;
      use3_q   <= 1'b0;
      op_valid <= 1'b0;
    end else begin
      if (issue_fire) begin
        act    <= 1'b1;
        use3_q <= issue_use3;
      end else if (phase == SL_RS3 && act) begin
        act <= 1'b0;
      end
      if (phase == SL_RS3 && act) op_valid <= 1'b1;
      else if (op_valid && op_ready) op_valid <= 1'b0;
    end
  end

  // operand capture
  always_ff @(posedge clk) begin
    if (issue_fire) begin
      rs2_q <= issue_rs2;
      rs3_q <= issue_rs3;
      rd_q  <= issue_rd;
      opa   <= rf_rdata;
    end
    if (phase == SL_RS2 && act) opb <= rf_rdata;
    if (phase == SL_RS3 && act) begin
      opc   <= use3_q ? rf_rdata : '0;
      op_rd <= rd_q;
    end
  end

  slot_col_fma #(.LANES(LANES), .XLEN(XLEN), .STAGES(FMA_STAGES), .AW(AW)) u_fma (
    .clk(clk), .rst_n(rst_n),
    .in_valid(op_valid), .in_ready(op_ready),
    .in_a(opa), .in_b(opb), .in_c(opc), .in_rd(op_rd),
    .out_valid(res_valid), .out_ready(res_ready),
    .out_data(res_data), .out_rd(res_rd)
  );

  // result buffer for results that miss a write slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
    end else if (buf_full) begin
      if (phase == SL_WR) buf_full <= 1'b0;
    end else if (res_valid && phase != SL_WR) begin
      buf_full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!buf_full && res_valid && phase != SL_WR) begin
      buf_data <= res_data;
      buf_rd   <= res_rd;
    end
  end

  // memory side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_serve;
      if (mem_serve && mem_req_store) mem_rdata <= rf_rdata;
    end
  end
endmodule

// File: rtl/slot_collector_chk.sv
module slot_collector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase,
  input logic       issue_fire,
  input logic       rf_we,
  input logic       rf_re,
  input logic       res_we,
  input logic       load_we,
  input logic       mem_serve,
  input logic       mem_ack,
  input logic       op_valid,
  input logic       buf_full,
  input logic       act,
  input logic       use3_q
);
  p_issue_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> phase == 2'd0);

  p_rw_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !rf_re);

  p_res_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> phase == 2'd3);

  p_load_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |-> phase == 2'd2);

  p_mem_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_serve |-> (phase == 2'd2) && !(act && use3_q));

  p_ack_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_serve |=> mem_ack);

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack |=> !mem_ack);

  p_buf_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && phase == 2'd3) |=> !buf_full);

  p_release_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> phase == 2'd3);
endmodule

bind slot_collector slot_collector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .issue_fire(issue_fire),
  .rf_we(rf_we), .rf_re(rf_re), .res_we(res_we), .load_we(load_we),
  .mem_serve(mem_serve), .mem_ack(mem_ack), .op_valid(op_valid),
  .buf_full(buf_full), .act(act), .use3_q(use3_q)
);

// File: tb/slot_collector_test.sv
module slot_collector_test;
  localparam int AW = 4;
  localparam int GW = 256;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] c;
    logic        use3;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{64'd3, 64'd5, 64'd7, 1'b1},
    '{64'd0, 64'd12345, 64'd99, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd1, 1'b1},
    '{64'h1_0000_0000, 64'h1_0000_0000, 64'd5, 1'b1},
    '{64'd9, 64'd9, 64'd100, 1'b0},
    '{64'h8000_0000_0000_0000, 64'd2, 64'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0, issue_use3 = 1'b0;
  logic [AW-1:0] issue_rs1 = '0, issue_rs2 = '0, issue_rs3 = '0, issue_rd = '0;
  logic mem_req_valid = 1'b0, mem_req_store = 1'b0;
  logic [AW-1:0] mem_req_addr = '0;
  logic [GW-1:0] mem_req_wdata = '0;
  logic issue_ready, mem_ack, issue_ready5, mem_ack5;
  logic [GW-1:0] mem_rdata, mem_rdata5;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  slot_collector uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_rs1(issue_rs1), .issue_rs2(issue_rs2), .issue_rs3(issue_rs3),
    .issue_rd(issue_rd), .issue_use3(issue_use3),
    .mem_req_valid(mem_req_valid), .mem_req_store(mem_req_store),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  slot_collector #(.FMA_STAGES(5)) uut_lat5 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready5),
    .issue_rs1(issue_rs1), .issue_rs2(issue_rs2), .issue_rs3(issue_rs3),
    .issue_rd(issue_rd), .issue_use3(issue_use3),
    .mem_req_valid(mem_req_valid), .mem_req_store(mem_req_store),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_ack(mem_ack5), .mem_rdata(mem_rdata5)
  );

  task automatic chk(input bit ok, input string req, input logic [GW-1:0] act_v,
                     input logic [GW-1:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [GW-1:0] lanes_of(input logic [63:0] base, input int step);
    logic [GW-1:0] r;
    for (int l = 0; l < 4; l++) r[l*64 +: 64] = base + 64'(l * step);
    return r;
  endfunction

  // lane-wise multiply then add, wrapped to 64 bits
  function automatic logic [GW-1:0] expect_of(input vec_t v);
    logic [GW-1:0] r;
    for (int l = 0; l < 4; l++) begin
      logic [127:0] full;
      full = 128'(v.a + 64'(l)) * 128'(v.b + 64'(2*l));
      if (v.use3) full = full + 128'(v.c + 64'(3*l));
      r[l*64 +: 64] = full[63:0];
    end
    return r;
  endfunction

  task automatic mem_op(input logic st, input logic [AW-1:0] addr, input logic [GW-1:0] wd,
                        output logic [GW-1:0] rd, output logic [GW-1:0] rd5, output int ack_cyc);
    int n = 0;
    mem_req_valid = 1'b1;
    mem_req_store = st;
    mem_req_addr  = addr;
    mem_req_wdata = wd;
    do begin
      @(negedge clk);
      n++;
    end while (!mem_ack && n < 40);
    ack_cyc = mem_ack ? cyc : -1;
    rd  = mem_rdata;
    rd5 = mem_rdata5;
    mem_req_valid = 1'b0;
  endtask

  task automatic issue_op(input logic [AW-1:0] r1, input logic [AW-1:0] r2,
                          input logic [AW-1:0] r3, input logic [AW-1:0] rdst,
                          input logic u3, output int fire_cyc);
    int n = 0;
    issue_valid = 1'b1;
    issue_rs1 = r1; issue_rs2 = r2; issue_rs3 = r3; issue_rd = rdst; issue_use3 = u3;
    while (!issue_ready && n < 40) begin
      @(negedge clk);
      n++;
    end
    fire_cyc = cyc;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic align0();
    do @(negedge clk); while (cyc % 4 != 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [GW-1:0] rd, rd5;
    int ack, t, t0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: state right after reset
    chk(issue_ready == 1'b1 && cyc == 0, "R1 issue_ready in first cycle", GW'(issue_ready), GW'(1));
    chk(mem_ack == 1'b0, "R1 mem_ack after reset", GW'(mem_ack), '0);
    chk(mem_rdata == '0, "R1 mem_rdata after reset", mem_rdata, '0);

    // R2: ready only in slot 0
    for (int k = 0; k < 8; k++) begin
      chk(issue_ready == (cyc % 4 == 0), "R2 issue_ready slot pattern", GW'(issue_ready),
          GW'(cyc % 4 == 0));
      @(negedge clk);
    end

    // R1: untouched group reads zero
    mem_op(1'b1, 4'd15, '0, rd, rd5, ack);
    chk(rd == '0, "R1 group zero after reset", rd, '0);
    chk(ack >= 0 && ack % 4 == 3, "R6 ack lands in slot 3", GW'(ack), GW'(3));

    // R7: load then store round trip
    mem_op(1'b0, 4'd12, {4{64'hA5A5_0000_1234_5678}}, rd, rd5, ack);
    chk(ack >= 0 && ack % 4 == 3, "R6 load ack in slot 3", GW'(ack), GW'(3));
    mem_op(1'b1, 4'd12, '0, rd, rd5, ack);
    chk(rd == {4{64'hA5A5_0000_1234_5678}}, "R7 store returns loaded group", rd,
        {4{64'hA5A5_0000_1234_5678}});

    // vector table: R3 arithmetic, R5 loads visible to later reads
    for (int i = 0; i < 6; i++) begin
      mem_op(1'b0, 4'd0, lanes_of(VECS[i].a, 1), rd, rd5, ack);
      mem_op(1'b0, 4'd1, lanes_of(VECS[i].b, 2), rd, rd5, ack);
      mem_op(1'b0, 4'd2, lanes_of(VECS[i].c, 3), rd, rd5, ack);
      issue_op(4'd0, 4'd1, 4'd2, AW'(4 + i), VECS[i].use3, t);
      chk(t % 4 == 0, "R2 issue taken in slot 0", GW'(t % 4), '0);
      repeat (14) @(negedge clk);
      mem_op(1'b1, AW'(4 + i), '0, rd, rd5, ack);
      chk(rd == expect_of(VECS[i]), "R3 R5 lane multiply-add result", rd, expect_of(VECS[i]));
      chk(rd5 == expect_of(VECS[i]), "R3 five-stage instance result", rd5, expect_of(VECS[i]));
    end

    // R4 / R7 / R8: three-operand issue with a store raised alongside
    align0();
    t0 = cyc;
    mem_req_valid = 1'b1; mem_req_store = 1'b1; mem_req_addr = 4'd10;
    issue_op(4'd0, 4'd1, 4'd2, 4'd10, 1'b1, t);
    chk(t == t0, "R2 issue accepted at once in slot 0", GW'(t), GW'(t0));
    mem_op(1'b1, 4'd10, '0, rd, rd5, ack);
    chk(ack == t0 + 7, "R7 request deferred past claimed slot", GW'(ack), GW'(t0 + 7));
    chk(rd == '0, "R4 store at T+6 sees old group", rd, '0);
    mem_op(1'b1, 4'd10, '0, rd, rd5, ack);
    chk(ack == t0 + 11, "R6 next free slot 2", GW'(ack), GW'(t0 + 11));
    chk(rd == expect_of(VECS[5]), "R4 R9 store at T+10 sees result", rd, expect_of(VECS[5]));
    chk(rd5 == '0, "R8 parked result not yet written at T+10", rd5, '0);
    mem_op(1'b1, 4'd10, '0, rd, rd5, ack);
    chk(rd5 == expect_of(VECS[5]), "R8 parked result written by T+14", rd5, expect_of(VECS[5]));

    // R6 / R7: two-operand issue lends slot 2 to a store in the same frame
    align0();
    t0 = cyc;
    mem_req_valid = 1'b1; mem_req_store = 1'b1; mem_req_addr = 4'd0;
    issue_op(4'd0, 4'd1, 4'd2, 4'd11, 1'b0, t);
    mem_op(1'b1, 4'd0, '0, rd, rd5, ack);
    chk(ack == t0 + 3, "R7 store served in lent slot", GW'(ack), GW'(t0 + 3));
    chk(rd == lanes_of(VECS[5].a, 1), "R7 lent-slot store data", rd, lanes_of(VECS[5].a, 1));

    // R2: request raised in slot 1 waits for the next slot 0
    repeat (12) @(negedge clk);
    align0();
    @(negedge clk);
    t0 = cyc;
    issue_op(4'd0, 4'd1, 4'd2, 4'd13, 1'b1, t);
    chk(t == t0 + 3, "R2 held request taken at next slot 0", GW'(t), GW'(t0 + 3));
    repeat (14) @(negedge clk);
    mem_op(1'b1, 4'd13, '0, rd, rd5, ack);
    chk(rd == expect_of(VECS[5]), "R3 held issue result", rd, expect_of(VECS[5]));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule